// File: doc/BRIEF.md
# Interprocessor Interrupt Command Register

This block is the 64-bit command register pair through which a processor's local interrupt controller sends interrupts to other processors. Software on the host bus first writes the destination word, then the command word. The command-word write is the send strobe. It captures the vector, delivery mode and level flag, resolves the destination into a bitmap with one bit per processor, and raises a request on an outbound message port. The request stays up until the port acknowledges it.

While a message waits for its acknowledge, a delivery-status bit reads as busy, and software polls it before it issues the next command. A command-word write that arrives while busy is dropped, and a sticky error flag records the drop. The shorthand field selects how the destination is formed: from the stored destination ID, the local processor only, every processor, or every processor except the local one. The local processor number is a parameter. Reads return the stored fields with the live busy bit and the externally supplied remote-read status merged in.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, msg_req and cmd_err are 0, and both command words read as zero while rr_status is 0.
- R2: A write to offset 0x310 stores bits 31:24 as the destination ID. Reading 0x310 returns that ID in bits 31:24, with all other bits zero.
- R3: A write to offset 0x300 while idle raises msg_req from the next cycle. The message carries vector = bits 7:0, mode = bits 10:8, logical = bit 11, level = bit 14 (1 assert, 0 deassert) and trig = bit 15. Bit 12 then reads 1.
- R4: While msg_req is high and msg_ack is low, every message output holds its value. One cycle after msg_ack is sampled high, msg_req and busy bit 12 are 0.
- R5: Shorthand bits 19:18 = 00 maps to a single bit at the stored destination ID. The map is all zero when the ID is not below NCPU.
- R6: Shorthand 01 maps to only bit LOCAL_ID.
- R7: Shorthand 10 maps to every one of the NCPU bits.
- R8: Shorthand 11 maps to every bit except LOCAL_ID.
- R9: A write to 0x300 while busy is ignored: the message and the stored fields are unchanged, and cmd_err becomes 1 and stays 1 until reset.
- R10: A read of 0x300 returns the stored fields in their write positions, the shorthand in bits 19:18, the live busy flag in bit 12 and the live rr_status input in bits 17:16.
- R11: A second command written in the cycle after busy clears is accepted, so two identical startup messages go out back to back.
- R12: Writes to any other offset change nothing, and reads of other offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rr_status | input | 2 | Remote read status merged into reads |
| msg_req | output | 1 | Outbound message request (busy) |
| msg_ack | input | 1 | Outbound port acceptance |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Logical destination mode flag |
| msg_level | output | 1 | Level assert (1) or deassert (0) |
| msg_trig | output | 1 | Trigger mode flag |
| msg_dest_map | output | NCPU | Resolved destination bitmap |
| cmd_err | output | 1 | Sticky flag for a dropped command write |

## Verification
Every cycle, the assertions check the handshake. An idle command write must raise the request, and a busy one must latch the error without disturbing the message. The message must stay stable until it is acknowledged, and an acknowledge must clear busy. The error flag must stay sticky. Each shorthand's map must have the right population and local bit. The bench scenarios are the only way to show the field positions on the bus and the exact map for a given destination ID, including an out-of-range ID. They also cover the live remote-read merge, the back-to-back startup pair and the inertness of unmapped offsets.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned LO_OFFS  = 'h300;
    localparam int unsigned HI_OFFS  = 'h310;
    localparam int unsigned BUSY_BIT = 12;
    localparam int unsigned RRS_LSB  = 16;
    localparam int unsigned SH_LSB   = 18;
    localparam int unsigned DEST_LSB = 24;

    typedef enum logic [1:0] {
        SH_FIELD   = 2'b00,
        SH_SELF    = 2'b01,
        SH_ALL_INC = 2'b10,
        SH_ALL_EXC = 2'b11
    } shorthand_e;

    typedef struct packed {
        shorthand_e  sh;
        logic        trig;
        logic        level;
        logic        logical;
        logic [2:0]  mode;
        logic [7:0]  vector;
    } cmd_fields_t;

    function automatic cmd_fields_t unpack_lo(input logic [WORD_W-1:0] w);
        cmd_fields_t f;
        f.vector  = w[7:0];
        f.mode    = w[10:8];
        f.logical = w[11];
        f.level   = w[14];
        f.trig    = w[15];
        f.sh      = shorthand_e'(w[SH_LSB+1:SH_LSB]);
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] pack_lo(input cmd_fields_t f,
                                                  input logic busy,
                                                  input logic [1:0] rrs);
        logic [WORD_W-1:0] w;
        w                      = '0;
        w[7:0]                 = f.vector;
        w[10:8]                = f.mode;
        w[11]                  = f.logical;
        w[BUSY_BIT]            = busy;
        w[14]                  = f.level;
        w[15]                  = f.trig;
        w[RRS_LSB+1:RRS_LSB]   = rrs;
        w[SH_LSB+1:SH_LSB]     = f.sh;
        return w;
    endfunction

endpackage

// File: rtl/ipi_bus_decode.sv
module ipi_bus_decode #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              sel_lo,
    output logic              sel_hi,
    output logic              wr_lo,
    output logic              wr_hi
);
    import ipi_pkg::*;

    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_OFFS);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_OFFS);

    always_comb begin
        sel_lo = (bus_addr == LO_A);
        sel_hi = (bus_addr == HI_A);
        wr_lo  = bus_wr && sel_lo;
        wr_hi  = bus_wr && sel_hi;
    end

    always_comb begin
        a_r12_one_select: assert (!(sel_lo && sel_hi));
    end
endmodule

// File: rtl/ipi_dest_resolve.sv
module ipi_dest_resolve #(
    parameter int unsigned NCPU     = 8,
    parameter int unsigned LOCAL_ID = 0,
    parameter int unsigned ID_W     = 8
) (
    input  ipi_pkg::shorthand_e sh,
    input  logic [ID_W-1:0]     dest_id,
    output logic [NCPU-1:0]     dest_map
);
    import ipi_pkg::*;

    for (genvar i = 0; i < NCPU; i++) begin : g_bit
        localparam bit IS_LOCAL = (i == LOCAL_ID);
        always_comb begin
            unique case (sh)
                SH_FIELD:   dest_map[i] = (dest_id == ID_W'(i));
                SH_SELF:    dest_map[i] = IS_LOCAL;
                SH_ALL_INC: dest_map[i] = 1'b1;
                SH_ALL_EXC: dest_map[i] = !IS_LOCAL;
                default:    dest_map[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        if (sh == SH_SELF)
            a_r6_self_only: assert ($countones(dest_map) == 1 && dest_map[LOCAL_ID]);
        if (sh == SH_ALL_INC)
            a_r7_all: assert (&dest_map);
        if (sh == SH_ALL_EXC)
            a_r8_all_but_self: assert ($countones(dest_map) == NCPU - 1 && !dest_map[LOCAL_ID]);
        if (sh == SH_FIELD)
            a_r5_at_most_one: assert ($onehot0(dest_map));
    end
endmodule

// File: rtl/ipi_send_ctrl.sv
module ipi_send_ctrl #(
    parameter int unsigned NCPU = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_lo,
    input  ipi_pkg::cmd_fields_t     new_fields,
    input  logic [NCPU-1:0]          new_map,
    input  logic                     msg_ack,
    output logic                     busy,
    output ipi_pkg::cmd_fields_t     fields_q,
    output logic [NCPU-1:0]          map_q,
    output logic                     cmd_err
);
    import ipi_pkg::*;

    logic accept;
    assign accept = wr_lo && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            fields_q <= '0;
            map_q    <= '0;
            cmd_err  <= 1'b0;
        end else begin
            if (accept) begin
                busy     <= 1'b1;
                fields_q <= new_fields;
                map_q    <= new_map;
            end else if (busy && msg_ack) begin
                busy <= 1'b0;
            end
            if (wr_lo && busy)
                cmd_err <= 1'b1;
        end
    end

    a_r3_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !busy) |=> busy);
    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (busy && !msg_ack) |=> (busy && $stable(fields_q) && $stable(map_q)));
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (busy && msg_ack) |=> !busy);
    a_r9_drop_flags_err: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && busy) |=> (cmd_err && $stable(fields_q) && $stable(map_q)));
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        cmd_err |=> cmd_err);
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NCPU     = 8,
    parameter int unsigned LOCAL_ID = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [1:0]        rr_status,
    output logic              msg_req,
    input  logic              msg_ack,
    output logic [7:0]        msg_vector,
    output logic [2:0]        msg_mode,
    output logic              msg_logical,
    output logic              msg_level,
    output logic              msg_trig,
    output logic [NCPU-1:0]   msg_dest_map,
    output logic              cmd_err
);
    import ipi_pkg::*;

    localparam int unsigned ID_W = WORD_W - DEST_LSB;

    logic            sel_lo, sel_hi, wr_lo, wr_hi, busy;
    logic [ID_W-1:0] dest_q;
    cmd_fields_t     new_fields, fields_q;
    logic [NCPU-1:0] new_map, map_q;

    ipi_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr(bus_wr), .bus_addr(bus_addr),
        .sel_lo(sel_lo), .sel_hi(sel_hi), .wr_lo(wr_lo), .wr_hi(wr_hi)
    );

    always_ff @(posedge clk) begin
        if (rst)        dest_q <= '0;
        else if (wr_hi) dest_q <= bus_wdata[WORD_W-1:DEST_LSB];
    end

    assign new_fields = unpack_lo(bus_wdata);

    ipi_dest_resolve #(.NCPU(NCPU), .LOCAL_ID(LOCAL_ID), .ID_W(ID_W)) u_res (
        .sh(new_fields.sh), .dest_id(dest_q), .dest_map(new_map)
    );

    ipi_send_ctrl #(.NCPU(NCPU)) u_ctl (
        .clk(clk), .rst(rst), .wr_lo(wr_lo), .new_fields(new_fields),
        .new_map(new_map), .msg_ack(msg_ack), .busy(busy),
        .fields_q(fields_q), .map_q(map_q), .cmd_err(cmd_err)
    );

    always_comb begin
        if (sel_lo)      bus_rdata = pack_lo(fields_q, busy, rr_status);
        else if (sel_hi) bus_rdata = {dest_q, {DEST_LSB{1'b0}}};
        else             bus_rdata = '0;
    end

    assign msg_req      = busy;
    assign msg_vector   = fields_q.vector;
    assign msg_mode     = fields_q.mode;
    assign msg_logical  = fields_q.logical;
    assign msg_level    = fields_q.level;
    assign msg_trig     = fields_q.trig;
    assign msg_dest_map = map_q;

    a_r2_dest_kept: assert property (@(posedge clk) disable iff (rst)
        !wr_hi |=> $stable(dest_q));
endmodule

// File: tb/tb_ipi_cmd_reg.sv
module tb_ipi_cmd_reg;
    localparam int NCPU = 8;
    localparam int LOC  = 2;
    localparam logic [11:0] LO = 12'h300, HI = 12'h310;

    logic clk = 0, rst = 1, bus_wr = 0, msg_ack = 0;
    logic [11:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [1:0] rr_status = 0;
    logic msg_req, msg_logical, msg_level, msg_trig, cmd_err;
    logic [7:0] msg_vector;
    logic [2:0] msg_mode;
    logic [NCPU-1:0] msg_dest_map;

    ipi_cmd_reg #(.ADDR_W(12), .NCPU(NCPU), .LOCAL_ID(LOC)) dut (.*);

    always #5 clk = ~clk;

    int checks = 0, fails = 0, seen = 0, ack_delay = 0;
    logic [39:0] exp_q[$];
    logic [7:0] cur_dest = 0;
    bit done = 0;

    task automatic check(bit ok, string req, logic [39:0] act, logic [39:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_map(logic [1:0] sh, logic [7:0] d);
        case (sh)
            2'b00:   return (d < NCPU) ? 8'(1 << d) : 8'h00;
            2'b01:   return 8'(1 << LOC);
            2'b10:   return 8'hFF;
            default: return ~8'(1 << LOC);
        endcase
    endfunction

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic send(logic [31:0] lo, bit expect_accept);
        if (expect_accept) exp_q.push_back({exp_map(lo[19:18], cur_dest), lo});
        wr(LO, lo);
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] d;
        n = 0;
        do begin rd(LO, d); n++; end while (d[12] && n < 100);
    endtask

    task automatic set_dest(logic [7:0] id);
        cur_dest = id;
        wr(HI, {id, 24'h00ABCD});
    endtask

    // monitor / scoreboard
    initial begin
        logic [39:0] e;
        logic [39:0] snap;
        forever begin
            @(negedge clk);
            if (!msg_req) continue;
            snap = {msg_dest_map, 16'h0, msg_trig, msg_level, 2'b0, msg_logical, msg_mode, msg_vector};
            if (exp_q.size() == 0) begin
                check(0, "R3 unexpected message", snap, 0);
            end else begin
                e = exp_q.pop_front();
                check(msg_vector == e[7:0] && msg_mode == e[10:8] && msg_logical == e[11]
                      && msg_level == e[14] && msg_trig == e[15], "R3 fields",
                      snap[15:0], {e[15:14], 2'b0, e[11:0]});
                check(msg_dest_map == e[39:32], "R5-R8 dest map", msg_dest_map, e[39:32]);
            end
            repeat (ack_delay) @(negedge clk);
            check({msg_dest_map, msg_vector, msg_mode} == {snap[39:32], snap[7:0], snap[10:8]},
                  "R4 stable until ack", {msg_dest_map, msg_vector}, {snap[39:32], snap[7:0]});
            msg_ack = 1;
            @(negedge clk);
            msg_ack = 0;
            seen++;
            check(!msg_req, "R4 req drops after ack", msg_req, 0);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n, s0;
        repeat (3) @(negedge clk);
        check(!msg_req && !cmd_err, "R1 reset outputs", {msg_req, cmd_err}, 0);
        rst = 0;
        rd(LO, d); check(d == 0, "R1 lo reads zero", d, 0);
        rd(HI, d); check(d == 0, "R1 hi reads zero", d, 0);

        set_dest(8'd5);
        rd(HI, d); check(d == 32'h0500_0000, "R2 dest readback", d, 32'h0500_0000);

        ack_delay = 3;
        send(32'h0000_4D31, 1);  // sh 00, level 1, logical 1, mode 5
        check(msg_req, "R3 req raised", msg_req, 1);
        rd(LO, d); check(d == 32'h0000_5D31, "R3 busy bit and fields", d, 32'h0000_5D31);
        wait_idle(n);
        rd(LO, d); check(d[12] == 0, "R4 busy cleared", d[12], 0);

        send(32'h0004_0040, 1); wait_idle(n);     // R6
        send(32'h0008_8041, 1); wait_idle(n);     // R7
        send(32'h000C_0042, 1); wait_idle(n);     // R8
        rd(LO, d); check(d == 32'h000C_0042, "R10 shorthand readback", d, 32'h000C_0042);
        set_dest(8'd9);
        send(32'h0000_0043, 1); wait_idle(n);     // R5 out-of-range -> empty map
        set_dest(8'd0);
        send(32'h0000_0044, 1); wait_idle(n);     // R5 id 0

        // R9 overrun
        ack_delay = 6;
        send(32'h0000_0150, 1);
        check(!cmd_err, "R9 no error yet", cmd_err, 0);
        send(32'h0008_0277, 0);
        check(cmd_err, "R9 error latched", cmd_err, 1);
        rd(LO, d); check(d[19:0] == 20'h01150, "R9 fields unchanged", d[19:0], 20'h01150);
        wait_idle(n);
        check(cmd_err, "R9 error sticky", cmd_err, 1);

        // R10 live remote read status
        rr_status = 2'b10;
        rd(LO, d); check(d[17:16] == 2'b10 && !d[12], "R10 rr status merge", d, 32'h0002_0150);
        rr_status = 2'b01;
        rd(LO, d); check(d[17:16] == 2'b01, "R10 rr status live", d[17:16], 1);
        rr_status = 2'b00;

        // R11 back-to-back startup pair
        ack_delay = 0;
        s0 = seen;
        set_dest(8'd3);
        send(32'h0000_0608, 1);
        wait_idle(n);
        check(n <= 3, "R11 quick turnaround", n, 3);
        send(32'h0000_0608, 1);
        wait_idle(n);
        repeat (2) @(negedge clk);
        check(seen - s0 == 2, "R11 two messages", seen - s0, 2);

        // R12 unmapped offset
        wr(12'h320, 32'hFFFF_FFFF);
        check(!msg_req, "R12 no send", msg_req, 0);
        rd(12'h320, d); check(d == 0, "R12 unmapped reads zero", d, 0);
        rd(HI, d); check(d == 32'h0300_0000, "R12 hi unchanged", d, 32'h0300_0000);
        rd(LO, d); check(d == 32'h0000_0608, "R12 lo unchanged", d, 32'h0000_0608);

        check(exp_q.size() == 0, "R3 all expected messages seen", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule